// File: doc/BRIEF.md
# Overlapping 0-1-1 Serial Pattern Detector

This block watches a serial bit stream, one bit per rising clock edge, and raises a flag in the cycle after the bits 0, 1, 1 have arrived in that order. It is a four-state Moore machine, so the flag is decoded from the registered state alone and never depends on the current input bit. Patterns may overlap: the 0 that follows a completed pattern can start the next one, so the stream 0-1-1-0-1-1 gives two flags.

The state is held in two J-K flip-flops. Their excitation terms come from explicit sum-of-products equations, not from a next-state case statement. The two raw state bits are brought out so that the stepping of the machine can be watched. An active-low asynchronous reset returns the machine to its idle state.

Top module: `det_seq_011`

## Requirements
- R1: While rst_ni is low, state_o reads 2'b00 and match_o is 0. When rst_ni is released, any partial pattern seen before the reset is forgotten.
- R2: The state encoding on state_o is fixed: idle = 2'b00, one 0 seen = 2'b01, 0 then 1 seen = 2'b11, full pattern seen = 2'b10.
- R3: From idle (00), a sampled 0 moves to 01 and a sampled 1 stays at 00.
- R4: From 01, a sampled 0 stays at 01 and a sampled 1 moves to 11.
- R5: From 11, a sampled 0 moves to 01 and a sampled 1 moves to 10.
- R6: From 10, a sampled 0 moves to 01 and a sampled 1 moves to 00. This allows patterns to overlap.
- R7: match_o is 1 exactly when state_o is 2'b10. It does not depend on bit_i in the same cycle.
- R8: match_o is high for exactly one cycle per pattern: the cycle after the edge that samples the final 1. It is never high in two consecutive cycles.
- R9: Each state bit behaves as a J-K flip-flop: J=K=1 toggles it, J=1,K=0 sets it, J=0,K=1 clears it, and J=K=0 holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit, sampled on each rising edge |
| match_o | output | 1 | Pattern flag, decoded from state |
| state_o | output | 2 | Raw state bits {q1, q0} |

## Verification
Two things can happen in the same cycle: the flag for a completed pattern is reported, and the first bit of the next pattern is sampled. This happens when a 0 arrives while the state is 10. The bench provokes it with back-to-back and overlapping streams such as 011011 and 0110110. It judges the result by comparing the flag and state_o, cycle by cycle, against a three-bit history model. The model also expects a reset that lands midway through a pattern to clear the partial match, so that a later lone 1 must not raise the flag.

// File: rtl/det_pkg.sv
package det_pkg;
  localparam int unsigned STATE_W = 2;
  localparam logic [STATE_W-1:0] ST_IDLE = 2'b00;
  localparam logic [STATE_W-1:0] ST_Z    = 2'b01;
  localparam logic [STATE_W-1:0] ST_ZO   = 2'b11;
  localparam logic [STATE_W-1:0] ST_HIT  = 2'b10;
endpackage

// File: rtl/det_jk_ff.sv
module det_jk_ff #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] j_i,
  input  logic [WIDTH-1:0] k_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (j_i & ~q_q) | (~k_i & q_q);
  end

  assign q_o = q_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    assert_jk_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (j_i[b] && k_i[b]) |=> (q_q[b] == !$past(q_q[b])));
    assert_jk_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (j_i[b] && !k_i[b]) |=> q_q[b]);
    assert_jk_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!j_i[b] && k_i[b]) |=> !q_q[b]);
    assert_jk_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!j_i[b] && !k_i[b]) |=> $stable(q_q[b]));
  end
endmodule

// File: rtl/det_excite.sv
module det_excite (
  input  logic       bit_i,
  input  logic [1:0] q_i,
  output logic [1:0] j_o,
  output logic [1:0] k_o
);
  logic q1, q0, nb;

  always_comb begin
    q1 = q_i[1];
    q0 = q_i[0];
    nb = ~bit_i;
    j_o[1] = bit_i & q0;
    // second term retires the full-match state unconditionally
    k_o[1] = (nb & q0) | (q1 & ~q0);
    // second term lets a 0 after a full match restart the pattern
    j_o[0] = (nb & ~q1) | (nb & q1 & ~q0);
    k_o[0] = bit_i & q1;
  end
endmodule

// File: rtl/det_seq_011.sv
module det_seq_011
  import det_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_i,
  output logic               match_o,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] q, j, k;

  det_excite u_excite (
    .bit_i (bit_i),
    .q_i   (q),
    .j_o   (j),
    .k_o   (k)
  );

  det_jk_ff #(.WIDTH(STATE_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .j_i    (j),
    .k_i    (k),
    .q_o    (q)
  );

  assign state_o = q;
  assign match_o = q[1] & ~q[0];

  assert_idle_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q == ST_IDLE) |=> (q == ($past(bit_i) ? ST_IDLE : ST_Z)));
  assert_zero_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q == ST_Z) |=> (q == ($past(bit_i) ? ST_ZO : ST_Z)));
  assert_zo_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q == ST_ZO) |=> (q == ($past(bit_i) ? ST_HIT : ST_Z)));
  assert_hit_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q == ST_HIT) |=> (q == ($past(bit_i) ? ST_IDLE : ST_Z)));
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
  assert_rise_after_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(bit_i));
endmodule

// File: tb/tb_det_seq_011.sv
module tb_det_seq_011;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b1;
  logic match;
  logic [1:0] state;

  int checks = 0;
  int failures = 0;
  logic [2:0] hist = 3'b111;
  logic [2:0] exp_q[$];   // {match, state}
  logic done = 1'b0;

  always #4 clk = ~clk;

  det_seq_011 dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .bit_i   (bit_in),
    .match_o (match),
    .state_o (state)
  );

  function automatic logic [1:0] ref_state(input logic [2:0] h);
    if (h == 3'b011)       return 2'b10;
    else if (h[1:0] == 2'b01) return 2'b11;
    else if (h[0] == 1'b0) return 2'b01;
    else                   return 2'b00;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {match,state} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // driver: at negedge, drive one bit and push expected result after next edge
  task automatic drive(input logic b);
    logic [1:0] s;
    @(negedge clk);
    bit_in = b;
    hist = {hist[1:0], b};
    s = ref_state(hist);
    exp_q.push_back({(s == 2'b10), s});
  endtask

  task automatic drive_str(input string s);
    for (int i = 0; i < s.len(); i++) drive(s[i] == "1");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset state", {match, state}, 3'b000);
    hist = 3'b111;
    @(negedge clk);
    check("R1 reset held", {match, state}, 3'b000);
    rst_n = 1'b1;
  endtask

  // monitor: pops one expected item per clock, sampled 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check("R2-map R3 R4 R5 R6 R7 R8 stream", {match, state}, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2;
    check("R1 reset at start", {match, state}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: idle holds on 1, enters 01 on 0
    drive_str("110");
    // R4 R5: 0 holds, then 1, 1 reach full match (R2 state 10, R7 match)
    drive_str("011");
    // R6: 1 after a match returns to idle; R8 one-cycle pulse
    drive_str("1");
    // R6 overlap: a 0 directly after a match restarts the pattern
    drive_str("0110110");
    // R5: 0 from 11 goes back to 01
    drive_str("01001");
    drive_str("1111");
    // R1: reset mid-pattern clears the partial match
    drive_str("01");
    do_reset();
    drive_str("1");
    drive_str("1");
    drive_str("0011");
    // random streams
    for (int n = 0; n < 2000; n++) drive(1'($urandom_range(0, 1)));
    do_reset();
    for (int n = 0; n < 500; n++) drive(1'($urandom_range(0, 3) != 0));
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule